// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This block sits between a 64-bit integer datapath and a byte-addressed data memory port that is 64 bits wide. When the datapath loads, the block reads the doubleword or doublewords that hold the requested bytes. It extracts those bytes in little-endian order, with the lowest address as the least significant byte. It then widens the result to 64 bits, by sign extension or by zero extension. When the datapath stores, the block moves the low bytes of the source operand into the matching memory byte lanes and builds a byte-enable mask for each memory beat.

Accesses are 1, 2, 4 or 8 bytes and need not be aligned. An access whose bytes run past the end of one doubleword is split into two memory beats at consecutive doubleword addresses. The split does not trap. The block takes one request at a time and reports `busy` while it runs the request. Requests that arrive while it is busy are dropped. Each load ends with a one-cycle `load_valid` pulse.

Top module: `ls_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req` and `load_valid` are 0.
- R2: Load bytes are gathered little-endian: the byte at `req_addr + k` comes from lane `(req_addr + k) mod 8` (bits 8*lane+7..8*lane) of its doubleword and lands in result bits 8k+7..8k.
- R3: With `req_unsigned` = 0 and `req_size` 00 (byte), 01 (half) or 10 (word), the load result copies the top fetched bit into all higher result bits.
- R4: With `req_unsigned` = 1 and `req_size` 00, 01 or 10, all result bits above the fetched bytes are 0.
- R5: With `req_size` 11 (doubleword), the load returns all 64 fetched bits unchanged, and `req_unsigned` has no effect on the result.
- R6: A store writes only the lowest 1, 2, 4 or 8 bytes of `req_wdata`, placed in the lanes that their addresses select. Write-data lanes that are not enabled carry 0, and memory bytes outside the access keep their contents.
- R7: When the low three address bits plus the access size in bytes exceed 8, the access uses two beats. The first beat goes to the aligned doubleword address and carries the low-order bytes. The second beat goes to that address plus 8 and carries the rest. Otherwise a single beat is issued. Every `mem_addr` has its low three bits at zero.
- R8: The store byte mask (1, 3, 0F or FF hex by size) is shifted left by the low three address bits. Bits that shift past lane 7 become the low bits of the second beat's `mem_be`, and every store beat enables at least one byte.
- R9: `load_valid` is high for exactly one cycle, in the cycle after the final read beat's `mem_rvalid`, and `load_data` holds the result in that cycle.
- R10: `busy` is high from the cycle after a request is accepted until the access completes. A `req_valid` seen while `busy` is high is ignored and causes no memory beat.
- R11: The first beat is issued in the cycle after acceptance. A split store issues its second beat in the next cycle. A split load issues its second beat in the cycle after the first `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 doubleword |
| req_unsigned | input | 1 | Zero-extend the load result (ignored for doubleword) |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Store source operand |
| busy | output | 1 | An access is in progress |
| mem_req | output | 1 | Memory beat issued this cycle |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Doubleword-aligned beat address |
| mem_wdata | output | 64 | Lane-placed write data |
| mem_be | output | 8 | Per-lane write enables (0 on reads) |
| mem_rvalid | input | 1 | Read data for the outstanding read beat |
| mem_rdata | input | 64 | Read doubleword |
| load_valid | output | 1 | One-cycle load completion pulse |
| load_data | output | 64 | Extended load result |

## Verification
The embedded properties watch the protocol shape on every cycle. They check that `load_valid` is a single-cycle pulse that coincides with an idle block, that back-to-back write beats step by exactly one doubleword, that every write beat enables some lane, and that the rise of `busy` coincides with a memory beat. Byte placement, the choice between sign and zero extension, the exact beat counts and latencies, and the rule that dropped requests leave no trace depend on the particular address, size and data. Only the bench's scenarios show these. The scenarios compare every cycle against a behavioural memory image at two read latencies. They cover offsets that end exactly at lane 7 and offsets that cross into the next doubleword.

// File: rtl/ls_aligner.sv
module ls_aligner #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    mem_be,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          load_valid,
  output logic [63:0]   load_data
);

  typedef enum logic [2:0] {S_IDLE, S_BEAT0, S_WAIT0, S_BEAT1, S_WAIT1} state_t;

  state_t          state;
  logic            st_q, uns_q, split_q;
  logic [1:0]      size_q;
  logic [2:0]      off_q;
  logic [AW-1:0]   base_q;
  logic [127:0]    wide_q;
  logic [15:0]     mask_q;
  logic [63:0]     lo_q;

  logic [3:0]      nbytes;
  logic            split_d;
  logic [63:0]     keep_d;
  logic [7:0]      bmask_d;
  logic            accept, finish;
  logic [127:0]    cat;
  logic [63:0]     raw, ext;

  assign accept  = req_valid && (state == S_IDLE);
  assign nbytes  = 4'd1 << req_size;
  assign split_d = ({1'b0, req_addr[2:0]} + nbytes) > 4'd8;

  always_comb begin
    case (req_size)
      2'b00:   begin keep_d = {56'b0, req_wdata[7:0]};  bmask_d = 8'h01; end
      2'b01:   begin keep_d = {48'b0, req_wdata[15:0]}; bmask_d = 8'h03; end
      2'b10:   begin keep_d = {32'b0, req_wdata[31:0]}; bmask_d = 8'h0F; end
      default: begin keep_d = req_wdata;                bmask_d = 8'hFF; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (req_valid) state <= S_BEAT0;
        S_BEAT0: state <= st_q ? (split_q ? S_BEAT1 : S_IDLE) : S_WAIT0;
        S_WAIT0: if (mem_rvalid) state <= split_q ? S_BEAT1 : S_IDLE;
        S_BEAT1: state <= st_q ? S_IDLE : S_WAIT1;
        S_WAIT1: if (mem_rvalid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      st_q    <= req_store;
      uns_q   <= req_unsigned;
      size_q  <= req_size;
      off_q   <= req_addr[2:0];
      split_q <= split_d;
      base_q  <= {req_addr[AW-1:3], 3'b000};
      wide_q  <= {64'b0, keep_d} << {req_addr[2:0], 3'b000};
      mask_q  <= {8'b0, bmask_d} << req_addr[2:0];
    end
    if (state == S_WAIT0 && mem_rvalid) lo_q <= mem_rdata;
  end

  assign busy      = state != S_IDLE;
  assign mem_req   = (state == S_BEAT0) || (state == S_BEAT1);
  assign mem_we    = mem_req && st_q;
  assign mem_addr  = base_q + ((state == S_BEAT1) ? AW'(8) : AW'(0));
  assign mem_wdata = !mem_we ? 64'b0 : (state == S_BEAT1) ? wide_q[127:64] : wide_q[63:0];
  assign mem_be    = !mem_we ? 8'b0  : (state == S_BEAT1) ? mask_q[15:8]   : mask_q[7:0];

  assign cat    = (state == S_WAIT1) ? {mem_rdata, lo_q} : {64'b0, mem_rdata};
  assign raw    = 64'(cat >> {off_q, 3'b000});
  assign finish = mem_rvalid && (((state == S_WAIT0) && !split_q) || (state == S_WAIT1));

  always_comb begin
    case (size_q)
      2'b00:   ext = uns_q ? {56'b0, raw[7:0]}  : {{56{raw[7]}},  raw[7:0]};
      2'b01:   ext = uns_q ? {48'b0, raw[15:0]} : {{48{raw[15]}}, raw[15:0]};
      2'b10:   ext = uns_q ? {32'b0, raw[31:0]} : {{32{raw[31]}}, raw[31:0]};
      default: ext = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      load_data  <= 64'b0;
    end else begin
      load_valid <= finish;
      if (finish) load_data <= ext;
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !load_valid);

  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> !busy);

  p_split_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(8)));

  p_store_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 8'h00));

  p_first_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req);

endmodule

// File: tb/ls_aligner_bench.sv
`timescale 1ns/1ps
module ls_aligner_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_store, req_unsigned;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [63:0]   req_wdata;
  logic          busy, mem_req, mem_we, load_valid;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata, load_data;
  logic [7:0]    mem_be;
  logic          mem_rvalid;

  always #4 clk = ~clk;

  ls_aligner #(.AW(AW)) u_ls_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .load_valid(load_valid), .load_data(load_data));

  logic [7:0] mem_b [0:127];
  logic [7:0] ref_b [0:127];
  int lat = 1;
  int pend = 0;
  logic [AW-1:0] pend_addr;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    mem_rdata  = 64'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid = 1'b1;
        for (int j = 0; j < 8; j++) mem_rdata[8*j +: 8] = mem_b[(pend_addr[6:0] & 7'h78) + j];
      end
    end
    if (rst_n && mem_req && !mem_we) begin
      pend = lat;
      pend_addr = mem_addr;
    end
    if (rst_n && mem_req && mem_we)
      for (int j = 0; j < 8; j++)
        if (mem_be[j]) mem_b[(mem_addr[6:0] & 7'h78) + j] = mem_wdata[8*j +: 8];
  end

  function automatic logic [63:0] widen(input logic [63:0] v, input int n, input bit uns);
    logic [63:0] r = 64'b0;
    for (int k = 0; k < 8*n; k++) r[k] = v[k];
    if (!uns) for (int k = 8*n; k < 64; k++) r[k] = v[8*n-1];
    return r;
  endfunction

  task automatic do_op(input bit st, input logic [1:0] sz, input bit uns,
                       input logic [AW-1:0] a, input logic [63:0] wd, input bit junk);
    int n, off, T, b1c, k;
    bit split, exp_busy, exp_req, ok;
    logic [63:0] fetched, expv, exp_wd;
    logic [7:0] exp_be;
    string rq;
    n = 1 << sz;
    off = int'(a[2:0]);
    split = (off + n) > 8;
    T = st ? (split ? 2 : 1) : (split ? 2*lat + 2 : lat + 1);
    b1c = st ? 1 : lat + 1;
    fetched = 64'b0;
    for (int i = 0; i < n; i++) fetched[8*i +: 8] = ref_b[int'(a[6:0]) + i];
    expv = widen(fetched, n, uns || (n == 8));
    rq = (n == 8) ? "R2 R5" : (uns ? "R2 R4" : "R2 R3");
    if (st) for (int i = 0; i < n; i++) ref_b[int'(a[6:0]) + i] = wd[8*i +: 8];
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_addr = a; req_wdata = wd;
    for (int c = 0; c <= T + 1; c++) begin
      @(negedge clk);
      exp_busy = c < T;
      exp_req  = (c == 0) || (split && c == b1c);
      chk(busy == exp_busy, "R10 busy", 64'(busy), 64'(exp_busy));
      chk(mem_req == exp_req, "R11 beat timing", 64'(mem_req), 64'(exp_req));
      if (exp_req) begin
        int beat = (c == 0) ? 0 : 1;
        chk(mem_addr == ((a & ~AW'(7)) + AW'(8*beat)), "R7 beat address", 64'(mem_addr),
            64'((a & ~AW'(7)) + AW'(8*beat)));
        chk(mem_we == st, "R11 beat kind", 64'(mem_we), 64'(st));
        if (st) begin
          exp_be = 8'b0; exp_wd = 64'b0;
          for (int j = 0; j < 8; j++) begin
            k = 8*beat + j - off;
            if (k >= 0 && k < n) begin
              exp_be[j] = 1'b1;
              exp_wd[8*j +: 8] = wd[8*k +: 8];
            end
          end
          chk(mem_be == exp_be, "R8 byte enables", 64'(mem_be), 64'(exp_be));
          chk(mem_wdata == exp_wd, "R6 lane data", mem_wdata, exp_wd);
        end
      end
      chk(load_valid == (!st && c == T), "R9 valid pulse", 64'(load_valid), 64'(!st && c == T));
      if (!st && c == T) chk(load_data == expv, rq, load_data, expv);
      if (junk && c < T) begin
        req_valid = 1'b1; req_store = 1'b1; req_size = 2'b11;
        req_addr = AW'(8'h68); req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      end else begin
        req_valid = 1'b0;
      end
    end
    if (st) begin
      ok = 1'b1;
      for (int i = 0; i < 128; i++) if (mem_b[i] !== ref_b[i]) ok = 1'b0;
      chk(ok, "R6 memory image", 64'(ok), 64'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem_b[i] = 8'(i * 157 + 3);
      ref_b[i] = mem_b[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'b00;
    req_unsigned = 1'b0; req_addr = '0; req_wdata = 64'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_req && !load_valid, "R1 reset", {busy, mem_req, load_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !load_valid, "R1 after reset", {busy, mem_req, load_valid}, 64'd0);

    for (int pass = 0; pass < 2; pass++) begin
      lat = (pass == 0) ? 1 : 3;
      do_op(1, 2'b11, 0, AW'(8'h10), 64'hF1E2_D3C4_85A6_9788, 0);
      do_op(0, 2'b00, 0, AW'(8'h11), 64'b0, 0);
      do_op(0, 2'b00, 1, AW'(8'h11), 64'b0, 1);
      do_op(0, 2'b01, 0, AW'(8'h12), 64'b0, 0);
      do_op(0, 2'b01, 1, AW'(8'h12), 64'b0, 0);
      do_op(0, 2'b10, 0, AW'(8'h14), 64'b0, 0);
      do_op(0, 2'b10, 1, AW'(8'h14), 64'b0, 0);
      do_op(0, 2'b11, 1, AW'(8'h10), 64'b0, 0);
      do_op(0, 2'b11, 0, AW'(8'h10), 64'b0, 0);
      do_op(1, 2'b00, 0, AW'(8'h23), 64'h1122_3344_5566_77AB, 1);
      do_op(1, 2'b01, 0, AW'(8'h2E), 64'h0000_0000_0000_9C81, 0);
      do_op(1, 2'b01, 0, AW'(8'h2F), 64'hFFFF_FFFF_FFFF_E5D4, 1);
      do_op(1, 2'b10, 0, AW'(8'h3D), 64'h1234_5678_8ABC_DEF0, 0);
      do_op(1, 2'b11, 0, AW'(8'h43), 64'h8001_0203_0405_0607, 1);
      do_op(0, 2'b01, 0, AW'(8'h2E), 64'b0, 0);
      do_op(0, 2'b01, 0, AW'(8'h2F), 64'b0, 1);
      do_op(0, 2'b01, 1, AW'(8'h2F), 64'b0, 0);
      do_op(0, 2'b10, 0, AW'(8'h3D), 64'b0, 0);
      do_op(0, 2'b10, 1, AW'(8'h3D), 64'b0, 0);
      do_op(0, 2'b11, 0, AW'(8'h43), 64'b0, 1);
      do_op(0, 2'b00, 0, AW'(8'h23), 64'b0, 0);
      do_op(0, 2'b10, 1, AW'(8'h57), 64'b0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule